// File: doc/BRIEF.md
# Palette DAC register interface

This block is the register side of a colour lookup table for a display. It keeps 256 normal colour entries and 4 overlay entries for the cursor. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. A processor reaches the table through a 32-bit register port with three word offsets. Offset 0 sets a shared entry index. Offset 4 moves colour components in and out of the normal table. Offset 12 writes the overlay entries. Every component travels in the top byte of the bus word.

One sequencer steps through red, green and blue. After the blue access it moves the index on by one. This lets software load a run of entries with one index write followed by a stream of data accesses. The display pipeline has its own combinational lookup port. That port returns the 24-bit colour of any entry and never disturbs the processor-side state.

Top module: `clut_regs`

## Requirements
- R1: On reset, every entry is black (0x000000) except entries 255, 256 and 258, which are white (0xFFFFFF). The index and the sequencer are cleared, so the first data access addresses red of entry 0.
- R2: A write at byte offset 0 loads the index from bus data bits 31:24 and returns the sequencer to red.
- R3: Data writes at offset 4 store bus bits 31:24 into the entry at the index: red on the first write, green on the second and blue on the third.
- R4: The sequencer only ever holds red, green or blue. After a blue access the index increments modulo 256 (255 wraps to 0) and the sequencer returns to red.
- R5: Data writes at offset 12 go to overlay entry 256 plus index bits 1:0. They follow the same red-green-blue sequence and increment the same index.
- R6: A read, with bus_rd high and bus_wr low, at any offset returns the current component of normal entry [index] in bus_rdata bits 31:24 with bits 23:0 zero. The value is registered and appears on the cycle after the read. A read then steps the sequencer the same way a data write does. bus_rdata holds its value until the next read.
- R7: Reads and data writes share one sequencer. A mixed series of accesses continues from whichever component is current.
- R8: A write at any offset other than 0, 4 or 12 changes no entry, no index, no sequencer state and no read data.
- R9: The lookup port is combinational. lut_idx selects entries 0 to 259 and returns {red[23:16], green[15:8], blue[7:0]}. An index above 259 returns zero. Reads never change the table.
- R10: When bus_wr and bus_rd are both high, only the write is performed. bus_rdata keeps its value and the sequencer steps at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_rd | input | 1 | Read strobe for one 32-bit word |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data; components and index in bits 31:24 |
| bus_rdata | output | 32 | Registered read data; component in bits 31:24 |
| lut_idx | input | 9 | Lookup index, 0 to 259 valid |
| lut_rgb | output | 24 | Colour of the looked-up entry |

## Verification
The assertions check on every cycle that the sequencer stays in one of its three legal states. They also check that an index write loads the top byte and clears the sequencer, and that a blue step by either a read or a write increments the index with wrap. They cover the rest of the control behaviour too: ignored offsets and read collisions leave the state and the read data untouched, the low read-data bits stay zero, and the lookup output holds steady when nothing is written. What the assertions cannot see is whether the right byte lands in the right component of the right entry. That includes the overlay aliasing by index bits 1:0 and the white reset defaults. The bench shows these by comparing every read and a full sweep of the lookup port against its own model of the table.

// File: rtl/clut_regs.sv
module clut_regs #(
  parameter int NORM = 256,
  parameter int OVL  = 4,
  parameter int CW   = 8,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [AW-1:0]               bus_addr,
  input  logic [DW-1:0]               bus_wdata,
  output logic [DW-1:0]               bus_rdata,
  input  logic [$clog2(NORM+OVL)-1:0] lut_idx,
  output logic [3*CW-1:0]             lut_rgb
);
  localparam int NENT = NORM + OVL;
  localparam int IW   = $clog2(NORM);
  localparam int LW   = $clog2(NENT);
  localparam int OW   = $clog2(OVL);
  localparam logic [AW-1:0] OFF_IDX = AW'(0);
  localparam logic [AW-1:0] OFF_PAL = AW'(4);
  localparam logic [AW-1:0] OFF_OVL = AW'(12);
  localparam logic [1:0] S_RED = 2'd0, S_GRN = 2'd1, S_BLU = 2'd2;

  logic [IW-1:0]   idx;
  logic [1:0]      seq;
  logic [3*CW-1:0] pal [NENT];

  wire wr_idx = bus_wr && (bus_addr == OFF_IDX);
  wire wr_pal = bus_wr && (bus_addr == OFF_PAL);
  wire wr_ovl = bus_wr && (bus_addr == OFF_OVL);
  wire wr_dat = wr_pal || wr_ovl;
  wire rd_dat = bus_rd && !bus_wr;
  wire step   = wr_dat || rd_dat;

  wire [CW-1:0] wbyte = bus_wdata[DW-1 -: CW];
  wire [DW-CW-1:0] unused_low = bus_wdata[DW-CW-1:0];

  wire [LW-1:0] tgt = wr_ovl ? (LW'(NORM) + LW'(idx[OW-1:0])) : LW'(idx);
  wire [3*CW-1:0] cur = pal[LW'(idx)];

  logic [CW-1:0] rbyte;
  always_comb begin
    case (seq)
      S_RED:   rbyte = cur[3*CW-1 -: CW];
      S_GRN:   rbyte = cur[2*CW-1 -: CW];
      default: rbyte = cur[CW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      seq       <= S_RED;
      bus_rdata <= '0;
      for (int i = 0; i < NENT; i++) begin
        if (i == NORM - 1 || i == NORM || i == NORM + 2)
          pal[i] <= '1;
        else
          pal[i] <= '0;
      end
    end else begin
      if (wr_idx) begin
        idx <= bus_wdata[DW-1 -: IW];
        seq <= S_RED;
      end else if (step) begin
        if (seq == S_BLU) begin
          seq <= S_RED;
          idx <= idx + 1'b1;
        end else begin
          seq <= seq + 2'd1;
        end
      end
      if (wr_dat) begin
        case (seq)
          S_RED:   pal[tgt][3*CW-1 -: CW] <= wbyte;
          S_GRN:   pal[tgt][2*CW-1 -: CW] <= wbyte;
          default: pal[tgt][CW-1:0]       <= wbyte;
        endcase
      end
      if (rd_dat)
        bus_rdata <= {rbyte, {(DW-CW){1'b0}}};
    end
  end

  assign lut_rgb = (lut_idx < LW'(NENT)) ? pal[lut_idx] : '0;
endmodule

module clut_regs_chk #(
  parameter int CW = 8,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int IW = 8,
  parameter int LW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [LW-1:0] lut_idx,
  input logic [3*CW-1:0] lut_rgb,
  input logic [IW-1:0] idx,
  input logic [1:0]    seq
);
  wire is_dat  = bus_wr && (bus_addr == AW'(4) || bus_addr == AW'(12));
  wire is_rd   = bus_rd && !bus_wr;
  wire is_skip = bus_wr && bus_addr != AW'(0) && bus_addr != AW'(4) && bus_addr != AW'(12);

  assert_seq_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq != 2'd3);

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0)) |=> (idx == $past(bus_wdata[DW-1 -: IW]) && seq == 2'd0));

  assert_wr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dat && seq == 2'd2) |=> (seq == 2'd0 && idx == IW'($past(idx) + 1'b1)));

  assert_rd_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && seq == 2'd2) |=> (seq == 2'd0 && idx == IW'($past(idx) + 1'b1)));

  assert_skip_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_skip |=> ($stable(idx) && $stable(seq) && $stable(bus_rdata)));

  assert_rdata_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-CW-1:0] == '0);

  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));

  assert_lut_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (!$stable(lut_idx) || $stable(lut_rgb)));
endmodule

bind clut_regs clut_regs_chk #(.CW(CW), .DW(DW), .AW(AW), .IW(IW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb),
  .idx(idx), .seq(seq)
);

// File: tb/clut_regs_test.sv
module clut_regs_test;
  localparam int PERIOD = 10;
  localparam int NENT = 260;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [23:0] m_pal [NENT];
  logic [7:0]  m_idx;
  int          m_seq;
  logic [31:0] m_rdata;

  clut_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] comp_of(logic [23:0] c, int s);
    return (s == 0) ? c[23:16] : (s == 1) ? c[15:8] : c[7:0];
  endfunction

  function automatic logic [23:0] put_comp(logic [23:0] c, int s, logic [7:0] v);
    logic [23:0] r = c;
    if (s == 0) r[23:16] = v; else if (s == 1) r[15:8] = v; else r[7:0] = v;
    return r;
  endfunction

  function automatic logic [23:0] lut_exp(logic [8:0] i);
    return (i < 9'(NENT)) ? m_pal[i] : 24'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NENT; i++)
      m_pal[i] = (i == 255 || i == 256 || i == 258) ? 24'hFFFFFF : 24'h0;
    m_idx = 0; m_seq = 0; m_rdata = 0;
  endtask

  task automatic model_step();
    if (m_seq == 2) begin m_seq = 0; m_idx = m_idx + 8'd1; end
    else m_seq++;
  endtask

  task automatic access(bit wr, bit rd, logic [3:0] a, logic [31:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    if (wr) begin
      if (a == 4'd0) begin m_idx = d[31:24]; m_seq = 0; end
      else if (a == 4'd4 || a == 4'd12) begin
        int t = (a == 4'd12) ? 256 + int'(m_idx[1:0]) : int'(m_idx);
        m_pal[t] = put_comp(m_pal[t], m_seq, d[31:24]);
        model_step();
      end
    end else if (rd) begin
      m_rdata = {comp_of(m_pal[m_idx], m_seq), 24'h0};
      model_step();
    end
  endtask

  task automatic look(string req, logic [8:0] i);
    lut_idx = i;
    #1;
    chk(req, {8'h0, lut_rgb}, {8'h0, lut_exp(i)});
  endtask

  task automatic rd_chk(string req);
    access(0, 1, 4'd4, 32'h0);
    chk(req, bus_rdata, m_rdata);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240517);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset defaults through lookup and first read
    chk("R1 rdata reset", bus_rdata, 32'h0);
    look("R1 entry0", 9'd0);
    look("R1 entry255", 9'd255);
    look("R1 entry256", 9'd256);
    look("R1 entry257", 9'd257);
    look("R1 entry258", 9'd258);
    look("R1 entry259", 9'd259);
    rd_chk("R1 first read red of 0");

    // R2/R3/R4 directed: load entry 255 then wrap to 0
    access(1, 0, 4'd0, 32'hFF00_0000);
    access(1, 0, 4'd4, 32'h1100_00AA);
    access(1, 0, 4'd4, 32'h2200_0000);
    access(1, 0, 4'd4, 32'h3300_0000);
    look("R3 entry255 rgb", 9'd255);
    access(1, 0, 4'd4, 32'h4400_0000);
    look("R4 wrap to entry0", 9'd0);

    // R5 overlay uses idx[1:0]
    access(1, 0, 4'd0, 32'h0700_0000);
    access(1, 0, 4'd12, 32'h5500_0000);
    access(1, 0, 4'd12, 32'h6600_0000);
    access(1, 0, 4'd12, 32'h7700_0000);
    look("R5 overlay 259", 9'd259);
    look("R5 normal 7 untouched", 9'd7);
    rd_chk("R5 idx advanced to 8");

    // R7 mixed: index 3, write red, read green, write blue
    access(1, 0, 4'd0, 32'h0300_0000);
    access(1, 0, 4'd4, 32'hA100_0000);
    rd_chk("R7 read green after write");
    access(1, 0, 4'd4, 32'hA300_0000);
    look("R7 entry3", 9'd3);
    rd_chk("R7 continues at entry4 red");

    // R8 ignored offsets
    access(1, 0, 4'd8, 32'hEE00_0000);
    rd_chk("R8 offset8 no step");
    access(1, 0, 4'd13, 32'hEE00_0000);
    look("R8 entry4", 9'd4);

    // R10 collision
    access(1, 1, 4'd4, 32'h9900_0000);
    chk("R10 rdata held", bus_rdata, m_rdata);
    look("R10 write done", 9'd4);

    // R9 out-of-range lookup
    look("R9 idx 300", 9'd300);
    look("R9 idx 511", 9'd511);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned k = $urandom % 100;
      logic [31:0] d = $urandom;
      if (k < 8)       access(1, 0, 4'd0, d);
      else if (k < 45) access(1, 0, 4'd4, d);
      else if (k < 55) access(1, 0, 4'd12, d);
      else if (k < 80) rd_chk("R6 random read");
      else if (k < 85) begin
        logic [3:0] a = 4'($urandom);
        if (a == 4'd0 || a == 4'd4 || a == 4'd12) a = 4'd8;
        access(1, 0, a, d);
        rd_chk("R8 random ignored write");
      end else if (k < 90) begin
        access(1, 1, (k[0] ? 4'd4 : 4'd12), d);
        chk("R10 random collision", bus_rdata, m_rdata);
      end else look("R9 random lookup", 9'($urandom));
    end

    for (int i = 0; i < 512; i++) look("R9 final sweep", 9'(i));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule